// File: doc/BRIEF.md
# Misaligned Load Data Aligner

This block is a small load unit placed between a processor's load request and a memory read port that serves only naturally aligned accesses. A load is given as an address, an access size (byte, halfword or word) and a signed flag, under a valid/ready handshake. The unit turns it into one aligned read. It waits for the read data and returns a 32-bit register value. Only one load is in flight at a time.

Misaligned loads do not fault. A misaligned word load returns the aligned word rotated right by eight bits for each byte of misalignment. An unsigned halfword load at an odd address returns the zero-extended aligned halfword rotated right by eight bits. A signed halfword load at an odd address becomes a signed byte load of the byte at that address. The memory returns little-endian 32-bit words, and the unit picks byte and halfword lanes from the low address bits.

Top module: `ld_align_unit`

## Requirements
- R1: After reset, `req_ready` is 1, and both `rsp_valid` and `mem_req` are 0.
- R2: A load is accepted only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the response has been taken. `req_valid` raised while the unit is busy has no effect.
- R3: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. `mem_size` uses 00 = byte, 01 = halfword, 10 = word. A word read clears address bits [1:0], a halfword read clears bit 0, and a byte read keeps the full address.
- R4: A word load with address bits [1:0] = 0 returns the memory word unchanged.
- R5: A word load with address bits [1:0] = k ≠ 0 reads the word at the address with bits [1:0] cleared and returns it rotated right by 8·k bits.
- R6: An unsigned halfword load (`req_size` = 01, `req_signed` = 0) returns the zero-extended halfword lane selected by address bit 1 (bits [15:0] when 0, [31:16] when 1). At an odd address it returns that 32-bit value rotated right by 8 bits.
- R7: A signed halfword load at an even address returns the selected halfword lane with bit 15 replicated into bits [31:16].
- R8: A signed halfword load at an odd address is issued as a byte read (`mem_size` = 00, full address). It returns byte lane [1:0] of the address, sign-extended from bit 7.
- R9: A byte load (`req_size` = 00) returns byte lane n = address bits [1:0] (data bits 8n+7..8n). The lane is sign-extended from bit 7 when `req_signed` = 1 and zero-extended otherwise.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_data` hold their values on the next cycle.
- R11: `req_size` = 11 behaves exactly as a word load (R4, R5), and its read is issued with `mem_size` = 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Unit can accept a load |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_signed | input | 1 | Sign-extend the result |
| mem_req | output | 1 | Aligned read request |
| mem_addr | output | ADDR_W | Read address, aligned to mem_size |
| mem_size | output | 2 | Size actually issued |
| mem_ack | input | 1 | Memory has taken the read request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Little-endian read word |
| rsp_valid | output | 1 | Formatted result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | DATA_W | Formatted register value |

## Verification
The bench runs every pairing of size code, signed flag and the four low address offsets over memory words whose sign bits vary. Offset 0 against offsets 1–3 separates the plain path from the rotations. Odd halfword offsets separate the rotated zero-extend case from the byte fallback taken by signed loads. Offset 2 against offset 0 shows whether the upper or the lower lane is chosen. Memory latencies and consumer stalls vary from load to load, and on alternate loads junk requests are driven while the unit is busy, to show that they are ignored and that a held result stays stable.

// File: rtl/ldal_pkg.sv
package ldal_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } ld_size_e;

   typedef enum logic [2:0] {
      FMT_WORD_ROT,
      FMT_HALF_ZX,
      FMT_HALF_ZX_ROT,
      FMT_HALF_SX,
      FMT_BYTE_ZX,
      FMT_BYTE_SX
   } ld_fmt_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_WAIT,
      ST_RESP
   } ld_state_e;

endpackage

// File: rtl/ldal_issue.sv
module ldal_issue
   import ldal_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              sgn,
   output ld_size_e          eff_size,
   output ld_fmt_e           fmt,
   output logic [ADDR_W-1:0] rd_addr
);

   always_comb begin
      eff_size = SZ_WORD;
      fmt      = FMT_WORD_ROT;
      case (ld_size_e'(size))
         SZ_BYTE: begin
            eff_size = SZ_BYTE;
            fmt      = sgn ? FMT_BYTE_SX : FMT_BYTE_ZX;
         end
         SZ_HALF: begin
            if (addr[0] && sgn) begin
               eff_size = SZ_BYTE;
               fmt      = FMT_BYTE_SX;
            end else if (addr[0]) begin
               eff_size = SZ_HALF;
               fmt      = FMT_HALF_ZX_ROT;
            end else begin
               eff_size = SZ_HALF;
               fmt      = sgn ? FMT_HALF_SX : FMT_HALF_ZX;
            end
         end
         default: begin
            eff_size = SZ_WORD;
            fmt      = FMT_WORD_ROT;
         end
      endcase
   end

   always_comb begin
      case (eff_size)
         SZ_WORD: rd_addr = {addr[ADDR_W-1:2], 2'b00};
         SZ_HALF: rd_addr = {addr[ADDR_W-1:1], 1'b0};
         default: rd_addr = addr;
      endcase
   end

endmodule

// File: rtl/ldal_format.sv
module ldal_format
   import ldal_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] word,
   input  logic [1:0]        lo,
   input  ld_fmt_e           fmt,
   output logic [DATA_W-1:0] result
);

   localparam int LANES = DATA_W / 8;

   logic [7:0]          lane [LANES];
   logic [7:0]          sel_byte;
   logic [15:0]         sel_half;
   logic [2*DATA_W-1:0] dbl;
   logic [DATA_W-1:0]   rot_word;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane[i] = word[8*i +: 8];
   end

   assign sel_byte = lane[lo];
   assign sel_half = lo[1] ? word[31:16] : word[15:0];
   assign dbl      = {word, word};
   assign rot_word = dbl[{lo, 3'b000} +: DATA_W];

   always_comb begin
      case (fmt)
         FMT_HALF_ZX:     result = {{(DATA_W-16){1'b0}}, sel_half};
         FMT_HALF_ZX_ROT: result = {sel_half[7:0], {(DATA_W-16){1'b0}}, sel_half[15:8]};
         FMT_HALF_SX:     result = {{(DATA_W-16){sel_half[15]}}, sel_half};
         FMT_BYTE_ZX:     result = {{(DATA_W-8){1'b0}}, sel_byte};
         FMT_BYTE_SX:     result = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
         default:         result = rot_word;
      endcase
   end

endmodule

// File: rtl/ldal_ctrl.sv
module ldal_ctrl
   import ldal_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [1:0]        in_lo,
   input  ld_size_e          in_size,
   input  ld_fmt_e           in_fmt,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   input  logic              mem_ack,
   input  logic              mem_rvalid,
   output logic [1:0]        lo_q,
   output ld_fmt_e           fmt_q,
   input  logic [DATA_W-1:0] fmt_data,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_data
);

   ld_state_e         state;
   logic [ADDR_W-1:0] addr_q;
   ld_size_e          size_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         addr_q <= '0;
         size_q <= SZ_BYTE;
         fmt_q  <= FMT_WORD_ROT;
         lo_q   <= '0;
         data_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               addr_q <= in_addr;
               size_q <= in_size;
               fmt_q  <= in_fmt;
               lo_q   <= in_lo;
               state  <= ST_REQ;
            end
            ST_REQ:  if (mem_ack) state <= ST_WAIT;
            ST_WAIT: if (mem_rvalid) begin
               data_q <= fmt_data;
               state  <= ST_RESP;
            end
            default: if (rsp_ready) state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign mem_req   = (state == ST_REQ);
   assign mem_addr  = addr_q;
   assign mem_size  = size_q;
   assign rsp_valid = (state == ST_RESP);
   assign rsp_data  = data_q;

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!rsp_valid && !mem_req));
   // R2
   done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready) |=> req_ready);
   // R3
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)));
   // R3
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_size == 2'b10) |-> (mem_addr[1:0] == 2'b00));
   // R3
   half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_size == 2'b01) |-> (mem_addr[0] == 1'b0));
   // R10
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

endmodule

// File: rtl/ld_align_unit.sv
module ld_align_unit
   import ldal_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_signed,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   input  logic              mem_ack,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_data
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("ld_align_unit: DATA_W must be 32");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("ld_align_unit: ADDR_W must be at least 2");
   end

   ld_size_e          dec_size;
   ld_fmt_e           dec_fmt;
   logic [ADDR_W-1:0] dec_addr;
   logic [1:0]        lo_q;
   ld_fmt_e           fmt_q;
   logic [DATA_W-1:0] fmt_data;

   ldal_issue #(.ADDR_W(ADDR_W)) u_issue (
      .addr     (req_addr),
      .size     (req_size),
      .sgn      (req_signed),
      .eff_size (dec_size),
      .fmt      (dec_fmt),
      .rd_addr  (dec_addr)
   );

   ldal_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .in_addr    (dec_addr),
      .in_lo      (req_addr[1:0]),
      .in_size    (dec_size),
      .in_fmt     (dec_fmt),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_size   (mem_size),
      .mem_ack    (mem_ack),
      .mem_rvalid (mem_rvalid),
      .lo_q       (lo_q),
      .fmt_q      (fmt_q),
      .fmt_data   (fmt_data),
      .rsp_valid  (rsp_valid),
      .rsp_ready  (rsp_ready),
      .rsp_data   (rsp_data)
   );

   ldal_format #(.DATA_W(DATA_W)) u_format (
      .word   (mem_rdata),
      .lo     (lo_q),
      .fmt    (fmt_q),
      .result (fmt_data)
   );

endmodule

// File: tb/sim_ld_align_unit.sv
module sim_ld_align_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_signed = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [1:0]  mem_size;
   logic        mem_ack = 1'b0;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_data;

   int checks = 0;
   int errors = 0;
   int outstanding = 0;
   logic [31:0] exp_data_q[$];
   string       exp_tag_q[$];
   logic [31:0] exp_maddr_q[$];
   logic [1:0]  exp_msize_q[$];

   always #10 clk = ~clk;

   ld_align_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_signed(req_signed),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
   );

   function automatic logic [31:0] mem_word(logic [31:0] wa);
      return (wa * 32'h9E37_79B9) ^ 32'h807F_F080;
   endfunction

   function automatic logic [31:0] exp_value(logic [31:0] a, logic [1:0] sz, logic sg, logic [31:0] w);
      logic [1:0]  k;
      logic [7:0]  b;
      logic [15:0] h;
      logic [31:0] z;
      k = a[1:0];
      b = 8'((w >> (8 * k)));
      h = k[1] ? w[31:16] : w[15:0];
      if (sz == 2'b00)
         return sg ? {{24{b[7]}}, b} : {24'h0, b};
      if (sz == 2'b01) begin
         if (!k[0]) return sg ? {{16{h[15]}}, h} : {16'h0, h};
         if (sg) return {{24{b[7]}}, b};
         z = {16'h0, h};
         return (z >> 8) | (z << 24);
      end
      if (k == 2'b00) return w;
      return (w >> (8 * k)) | (w << (32 - 8 * k));
   endfunction

   function automatic string tag_of(logic [1:0] k, logic [1:0] sz, logic sg);
      if (sz == 2'b11) return "R11";
      if (sz == 2'b10) return (k == 2'b00) ? "R4" : "R5";
      if (sz == 2'b00) return "R9";
      if (!sg) return "R6";
      return k[0] ? "R8" : "R7";
   endfunction

   task automatic do_load(logic [31:0] a, logic [1:0] sz, logic sg, bit junk);
      logic [31:0] ma;
      logic [1:0]  ms;
      if (sz[1]) begin ma = {a[31:2], 2'b00}; ms = 2'b10; end
      else if (sz == 2'b01 && !(a[0] && sg)) begin ma = {a[31:1], 1'b0}; ms = 2'b01; end
      else begin ma = a; ms = 2'b00; end
      exp_data_q.push_back(exp_value(a, sz, sg, mem_word({2'b00, a[31:2]})));
      exp_tag_q.push_back(tag_of(a[1:0], sz, sg));
      exp_maddr_q.push_back(ma);
      exp_msize_q.push_back(ms);
      @(posedge clk); #2;
      req_valid = 1'b1; req_addr = a; req_size = sz; req_signed = sg;
      do @(negedge clk); while (!req_ready);
      @(posedge clk); #2;
      outstanding++;
      if (junk) begin
         // R2: junk request while busy must be ignored
         req_addr = 32'hFFFF_FFFD; req_size = 2'b01; req_signed = 1'b1;
         @(posedge clk); #2;
         @(posedge clk); #2;
      end
      req_valid = 1'b0;
   endtask

   // memory responder with varying latency; checks issued address and size (R3)
   initial begin
      int lat = 0;
      forever begin
         @(posedge clk); #2;
         if (rst_n && mem_req) begin
            logic [31:0] ea, held;
            logic [1:0]  es;
            ea = exp_maddr_q.pop_front();
            es = exp_msize_q.pop_front();
            checks++;
            if (mem_addr !== ea || mem_size !== es) begin
               errors++;
               $display("FAIL R3 mem addr/size %h/%0d expected %h/%0d", mem_addr, mem_size, ea, es);
            end
            held = mem_addr;
            for (int i = 0; i < lat % 3; i++) begin
               @(posedge clk); #2;
               checks++;
               if (!mem_req || mem_addr !== held) begin
                  errors++;
                  $display("FAIL R3 request not held: req %b addr %h expected 1 %h", mem_req, mem_addr, held);
               end
            end
            mem_ack = 1'b1;
            @(posedge clk); #2;
            mem_ack = 1'b0;
            for (int i = 0; i < lat % 4; i++) begin
               @(posedge clk); #2;
            end
            mem_rvalid = 1'b1;
            mem_rdata  = mem_word({2'b00, held[31:2]});
            @(posedge clk); #2;
            mem_rvalid = 1'b0;
            mem_rdata  = 32'h0;
            lat++;
         end
      end
   end

   // consumer stall pattern
   initial begin
      logic [7:0] lfsr = 8'h5B;
      forever begin
         @(posedge clk); #2;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         rsp_ready = lfsr[0];
      end
   end

   // monitor: scoreboard compare, hold check (R10), busy check (R2)
   initial begin
      bit          hold = 1'b0;
      logic [31:0] hold_data = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (hold) begin
               checks++;
               if (!rsp_valid || rsp_data !== hold_data) begin
                  errors++;
                  $display("FAIL R10 held response: valid %b data %h expected 1 %h", rsp_valid, rsp_data, hold_data);
               end
            end
            if (outstanding > 0) begin
               checks++;
               if (req_ready) begin
                  errors++;
                  $display("FAIL R2 req_ready while busy: %b expected 0", req_ready);
               end
            end
            hold = rsp_valid && !rsp_ready;
            hold_data = rsp_data;
            if (rsp_valid && rsp_ready) begin
               logic [31:0] ed;
               string t;
               ed = exp_data_q.pop_front();
               t  = exp_tag_q.pop_front();
               checks++;
               if (rsp_data !== ed) begin
                  errors++;
                  $display("FAIL %s rsp_data %h expected %h", t, rsp_data, ed);
               end
               outstanding--;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired: outstanding %0d expected 0", outstanding);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n = 0;
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      checks++;
      // R1
      if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_req !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset state ready/rvalid/mreq %b%b%b expected 100", req_ready, rsp_valid, mem_req);
      end
      for (int b = 0; b < 3; b++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int sg = 0; sg < 2; sg++) begin
               for (int k = 0; k < 4; k++) begin
                  do_load(32'h0000_1000 + 32'(b * 52) + 32'(k), 2'(sz), 1'(sg), n[0]);
                  n++;
               end
            end
         end
      end
      while (exp_data_q.size() != 0) @(posedge clk);
      repeat (4) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule